// File: doc/BRIEF.md
# Trace capture ring buffer

This block is a trace sink. While capture is active, it writes each valid word from a simple valid/data trace input into an on-chip RAM. The RAM is used as a circular buffer. A sticky flag records that the write position has wrapped, which means the oldest entries have been overwritten. Software reaches everything through a small register bank addressed by byte offset. Writes take effect at the clock edge. Reads return data combinationally in the cycle of the read strobe.

Capture can end in three ways:
- Software clears the enable bit.
- A trigger arms a countdown of further words.
- A manual flush completes while the stop-on-flush option is set.

On the second and third of these, the block pads the current partial 4-word frame with filler words before it halts. This leaves the write position on a frame boundary. A status bit reports that the sink has stopped.

After capture ends, software places the read pointer and drains the RAM through a read-data register that advances on every read. Software also uses a write-data register that advances the write pointer, so it can clear the RAM before a run.

Top module: `trace_ring_buffer`

## Requirements
- R1: The register at offset 0x004 reads the RAM depth in words, with bit 31 clear. The trigger-count register at 0x01C reads back the last value written. Unmapped offsets read 0.
- R2: After reset, both pointers are 0, status (0x00C) reads 0, capture control (0x020) reads 0, formatter control (0x304) reads 0, and formatter status (0x300) reads 0x2 (stopped).
- R3: While capture is active (control bit 0 set and not halted), each cycle with trc_valid stores trc_data at the write pointer and advances the pointer modulo the depth. While capture is inactive, trace input stores nothing.
- R4: Status bit 0 (full) sets whenever the write pointer wraps from depth-1 to 0, whatever caused the write. It stays set until software writes the write-pointer register (0x018), which clears it.
- R5: A write to 0x024 while capture is inactive stores the written word at the write pointer and advances the pointer. While capture is active, such a write is ignored.
- R6: Reading 0x010 returns the RAM word at the read pointer in the cycle of the strobe, then advances the read pointer modulo the depth. Reads of any other offset leave the read pointer unchanged.
- R7: The read pointer (0x014) and write pointer (0x018) are writable. The written value is reduced modulo the depth and reads back.
- R8: When formatter control bit 13 is set, the first trc_trigger during active capture loads the count N from 0x01C. The word presented in the trigger cycle is not counted. After N further stored words, trace input is no longer stored. When bit 13 is clear, triggers have no effect.
- R9: After a trigger expiry or a flush, the block writes filler words of value 0 at the write pointer until the pointer is a multiple of 4. Trace words presented during padding are dropped. A stop leaves the write pointer 4-aligned.
- R10: Writing formatter control with bit 6 set starts a flush. Bit 6 reads 1 until the flush completes, then reads 0. Completion is when the pointer is aligned, or at once if capture is inactive. Capture halts at completion only if bit 12 is set.
- R11: Formatter status bit 1 reads 1 whenever capture is inactive and 0 while it is active. Writing control bit 0 = 1 while inactive clears any halt, and capture resumes from the current write pointer.
- R12: Formatter control bits 0, 12 and 13 read back as written. All other bits of that register read 0, apart from bit 6 while a flush is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect only for read data) |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | DW | Trace word |
| trc_trigger | input | 1 | Trigger event |

## Verification
The hardest state to reach from the ports is a halted sink whose write pointer was moved by padding rather than by trace words. The pad count depends on where the trigger landed within a frame and on the post-trigger count. The bench streams an unbroken run of words with the trigger placed so that expiry falls one slot short of a frame boundary. It keeps trace input valid through the padding cycle and afterwards, so that any word that should have been dropped would appear in the RAM dump. A flush issued at the last slot of the RAM makes the padding itself wrap the pointer, which checks that the full flag follows filler writes as well as trace writes.

// File: rtl/trb_pkg.sv
package trb_pkg;

   localparam int OFS_W = 12;
   typedef logic [OFS_W-1:0] ofs_t;

   // register byte offsets (decoded by software drivers)
   localparam ofs_t OFS_DEPTH   = 12'h004;
   localparam ofs_t OFS_STAT    = 12'h00C;
   localparam ofs_t OFS_RDATA   = 12'h010;
   localparam ofs_t OFS_RPTR    = 12'h014;
   localparam ofs_t OFS_WPTR    = 12'h018;
   localparam ofs_t OFS_POSTCNT = 12'h01C;
   localparam ofs_t OFS_CAPCTL  = 12'h020;
   localparam ofs_t OFS_WDATA   = 12'h024;
   localparam ofs_t OFS_FSTAT   = 12'h300;
   localparam ofs_t OFS_FCTL    = 12'h304;

   localparam int ST_FULL_BIT    = 0;
   localparam int CC_RUN_BIT     = 0;
   localparam int FC_EN_BIT      = 0;
   localparam int FC_FLUSH_BIT   = 6;
   localparam int FC_STOPFL_BIT  = 12;
   localparam int FC_STOPTRG_BIT = 13;
   localparam int FS_STOPPED_BIT = 1;

   typedef struct packed {
      logic stop_on_trig;
      logic stop_on_flush;
      logic fmt_en;
   } fmt_cfg_t;

   typedef enum logic [1:0] {
      TP_IDLE    = 2'd0,
      TP_COUNT   = 2'd1,
      TP_EXPIRED = 2'd2
   } trig_phase_t;

endpackage

// File: rtl/trb_ram.sv
module trb_ram #(
   parameter int DEPTH = 64,
   parameter int DW    = 32,
   parameter int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [PW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [PW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/trb_pointers.sv
module trb_pointers #(
   parameter int DEPTH = 64,
   parameter int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          w_adv,
   input  logic          w_load,
   input  logic          r_adv,
   input  logic          r_load,
   input  logic [31:0]   load_val,
   output logic [PW-1:0] wptr,
   output logic [PW-1:0] rptr,
   output logic          full
);

   localparam bit            POW2 = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [PW-1:0] w_inc, r_inc, load_ptr;

   assign load_ptr = PW'(load_val % 32'(DEPTH));

   generate
      if (POW2) begin : g_wrap_natural
         assign w_inc = wptr + PW'(1);
         assign r_inc = rptr + PW'(1);
      end else begin : g_wrap_compare
         assign w_inc = (wptr == LAST) ? '0 : wptr + PW'(1);
         assign r_inc = (rptr == LAST) ? '0 : rptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         full <= 1'b0;
      end else if (w_load) begin
         wptr <= load_ptr;
         full <= 1'b0;
      end else if (w_adv) begin
         wptr <= w_inc;
         if (wptr == LAST) full <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rptr <= '0;
      else if (r_load) rptr <= load_ptr;
      else if (r_adv)  rptr <= r_inc;
   end

endmodule

// File: rtl/trb_stop_ctrl.sv
module trb_stop_ctrl
   import trb_pkg::*;
#(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capturing,
   input  logic          start,
   input  logic          stop_on_trig,
   input  logic          stop_on_flush,
   input  logic          trig_in,
   input  logic          word_acc,
   input  logic          flush_req,
   input  logic          aligned,
   input  logic [CW-1:0] post_cnt,
   output logic          hold,
   output logic          pad_we,
   output logic          flush_busy,
   output logic          halted
);

   trig_phase_t   phase;
   logic [CW-1:0] remain;

   assign hold   = capturing & ((phase == TP_EXPIRED) | flush_busy);
   assign pad_we = hold & ~aligned;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= TP_IDLE;
         remain     <= '0;
         flush_busy <= 1'b0;
         halted     <= 1'b0;
      end else if (start) begin
         phase      <= TP_IDLE;
         flush_busy <= 1'b0;
         halted     <= 1'b0;
      end else begin
         if (!capturing) begin
            phase <= TP_IDLE;
         end else begin
            case (phase)
               TP_IDLE: begin
                  if (stop_on_trig && trig_in) begin
                     if (post_cnt == '0) begin
                        phase <= TP_EXPIRED;
                     end else begin
                        remain <= post_cnt;
                        phase  <= TP_COUNT;
                     end
                  end
               end
               TP_COUNT: begin
                  if (word_acc) begin
                     remain <= remain - CW'(1);
                     if (remain == CW'(1)) phase <= TP_EXPIRED;
                  end
               end
               TP_EXPIRED: begin
                  if (aligned) begin
                     phase  <= TP_IDLE;
                     halted <= 1'b1;
                  end
               end
               default: phase <= TP_IDLE;
            endcase
         end
         if (flush_busy && (!capturing || aligned)) begin
            flush_busy <= 1'b0;
            if (capturing && stop_on_flush) halted <= 1'b1;
         end
         if (flush_req) flush_busy <= 1'b1;
      end
   end

endmodule

// File: rtl/trace_ring_buffer.sv
module trace_ring_buffer
   import trb_pkg::*;
#(
   parameter int            DEPTH    = 64,
   parameter int            DW       = 32,
   parameter int            FRAME    = 4,
   parameter int            CW       = 32,
   parameter logic [DW-1:0] PAD_WORD = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [OFS_W-1:0] bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic             trc_valid,
   input  logic [DW-1:0]    trc_data,
   input  logic             trc_trigger
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int FB = (FRAME > 1) ? $clog2(FRAME) : 1;

   generate
      if (DW < 1 || DW > 32) begin : g_bad_dw
         $error("trace_ring_buffer: DW must lie in 1..32");
      end
      if (CW < 1 || CW > 32) begin : g_bad_cw
         $error("trace_ring_buffer: CW must lie in 1..32");
      end
      if (FRAME < 2 || (FRAME & (FRAME - 1)) != 0) begin : g_bad_frame
         $error("trace_ring_buffer: FRAME must be a power of two, at least 2");
      end
      if (DEPTH < FRAME || (DEPTH % FRAME) != 0) begin : g_bad_depth
         $error("trace_ring_buffer: DEPTH must be a whole number of frames");
      end
   endgenerate

   // register decode
   logic wr_wptr, wr_rptr, wr_wdata, wr_capctl, wr_fctl, wr_post, rd_data;
   assign wr_wptr   = bus_wr && (bus_addr == OFS_WPTR);
   assign wr_rptr   = bus_wr && (bus_addr == OFS_RPTR);
   assign wr_wdata  = bus_wr && (bus_addr == OFS_WDATA);
   assign wr_capctl = bus_wr && (bus_addr == OFS_CAPCTL);
   assign wr_fctl   = bus_wr && (bus_addr == OFS_FCTL);
   assign wr_post   = bus_wr && (bus_addr == OFS_POSTCNT);
   assign rd_data   = bus_rd && (bus_addr == OFS_RDATA);

   logic          cap_en;
   fmt_cfg_t      cfg;
   logic [CW-1:0] post_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_en   <= 1'b0;
         cfg      <= '0;
         post_cnt <= '0;
      end else begin
         if (wr_capctl) cap_en <= bus_wdata[CC_RUN_BIT];
         if (wr_post)   post_cnt <= bus_wdata[CW-1:0];
         if (wr_fctl) begin
            cfg.fmt_en        <= bus_wdata[FC_EN_BIT];
            cfg.stop_on_flush <= bus_wdata[FC_STOPFL_BIT];
            cfg.stop_on_trig  <= bus_wdata[FC_STOPTRG_BIT];
         end
      end
   end

   // datapath control
   logic          halted, hold, pad_req, flush_busy, capturing, start, flush_req;
   logic          trace_acc, sw_we, pad_go, mem_we, aligned, full;
   logic [PW-1:0] wptr, rptr;
   logic [DW-1:0] mem_wdata, ram_rdata;

   assign capturing = cap_en & ~halted;
   assign start     = wr_capctl & bus_wdata[CC_RUN_BIT] & ~capturing;
   assign flush_req = wr_fctl & bus_wdata[FC_FLUSH_BIT];
   assign aligned   = (wptr[FB-1:0] == '0);

   assign trace_acc = capturing & trc_valid & ~hold & ~wr_wptr;
   assign sw_we     = wr_wdata & ~capturing;
   assign pad_go    = pad_req & ~wr_wptr;
   assign mem_we    = trace_acc | sw_we | pad_go;

   always_comb begin
      if (trace_acc)  mem_wdata = trc_data;
      else if (sw_we) mem_wdata = bus_wdata[DW-1:0];
      else            mem_wdata = PAD_WORD;
   end

   trb_pointers #(.DEPTH(DEPTH), .PW(PW)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .w_adv    (mem_we),
      .w_load   (wr_wptr),
      .r_adv    (rd_data & ~wr_rptr),
      .r_load   (wr_rptr),
      .load_val (bus_wdata),
      .wptr     (wptr),
      .rptr     (rptr),
      .full     (full)
   );

   trb_ram #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_ram (
      .clk   (clk),
      .we    (mem_we),
      .waddr (wptr),
      .wdata (mem_wdata),
      .raddr (rptr),
      .rdata (ram_rdata)
   );

   trb_stop_ctrl #(.CW(CW)) u_stop (
      .clk           (clk),
      .rst_n         (rst_n),
      .capturing     (capturing),
      .start         (start),
      .stop_on_trig  (cfg.stop_on_trig),
      .stop_on_flush (cfg.stop_on_flush),
      .trig_in       (trc_trigger),
      .word_acc      (trace_acc),
      .flush_req     (flush_req),
      .aligned       (aligned),
      .post_cnt      (post_cnt),
      .hold          (hold),
      .pad_we        (pad_req),
      .flush_busy    (flush_busy),
      .halted        (halted)
   );

   // register read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_DEPTH:   bus_rdata = 32'(DEPTH) & 32'h7FFF_FFFF;
         OFS_STAT:    bus_rdata[ST_FULL_BIT] = full;
         OFS_RDATA:   bus_rdata[DW-1:0] = ram_rdata;
         OFS_RPTR:    bus_rdata[PW-1:0] = rptr;
         OFS_WPTR:    bus_rdata[PW-1:0] = wptr;
         OFS_POSTCNT: bus_rdata[CW-1:0] = post_cnt;
         OFS_CAPCTL:  bus_rdata[CC_RUN_BIT] = cap_en;
         OFS_FSTAT:   bus_rdata[FS_STOPPED_BIT] = ~capturing;
         OFS_FCTL: begin
            bus_rdata[FC_EN_BIT]      = cfg.fmt_en;
            bus_rdata[FC_FLUSH_BIT]   = flush_busy;
            bus_rdata[FC_STOPFL_BIT]  = cfg.stop_on_flush;
            bus_rdata[FC_STOPTRG_BIT] = cfg.stop_on_trig;
         end
         default:     bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/trb_checker.sv
module trb_checker
   import trb_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int PW    = 6,
   parameter int FB    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [OFS_W-1:0] bus_addr,
   input logic             flush_req,
   input logic             trc_valid,
   input logic [PW-1:0]    wptr,
   input logic [PW-1:0]    rptr,
   input logic             full,
   input logic             capturing,
   input logic             hold,
   input logic             halted,
   input logic             flush_busy
);

   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == LAST) ? '0 : p + PW'(1);
   endfunction

   logic wptr_wr, rptr_wr;
   assign wptr_wr = bus_wr && (bus_addr == OFS_WPTR);
   assign rptr_wr = bus_wr && (bus_addr == OFS_RPTR);

   assert_wptr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wptr <= LAST);

   assert_capture_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      capturing && trc_valid && !hold && !wptr_wr |=> wptr == step($past(wptr)));

   assert_idle_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !capturing && !wptr_wr && !(bus_wr && bus_addr == OFS_WDATA) |=> $stable(wptr));

   assert_sw_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      capturing && !trc_valid && !hold && bus_wr && bus_addr == OFS_WDATA |=> $stable(wptr));

   assert_full_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      full && !wptr_wr |=> full);

   assert_full_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wptr_wr |=> !full);

   assert_read_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == OFS_RDATA && !rptr_wr |=> rptr == step($past(rptr)));

   assert_halt_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) && !$past(wptr_wr) |-> wptr[FB-1:0] == '0);

   assert_flush_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> flush_busy);

endmodule

bind trace_ring_buffer trb_checker #(.DEPTH(DEPTH), .PW(PW), .FB(FB)) u_trb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .flush_req  (flush_req),
   .trc_valid  (trc_valid),
   .wptr       (wptr),
   .rptr       (rptr),
   .full       (full),
   .capturing  (capturing),
   .hold       (hold),
   .halted     (halted),
   .flush_busy (flush_busy)
);

// File: tb/trace_ring_buffer_bench.sv
module trace_ring_buffer_bench;

   localparam int D = 16;

   localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RDATA = 12'h010,
                           A_RPTR = 12'h014, A_WPTR = 12'h018, A_POST = 12'h01C,
                           A_CAP = 12'h020, A_WDATA = 12'h024, A_FSTAT = 12'h300,
                           A_FCTL = 12'h304;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        trc_valid = 1'b0, trc_trigger = 1'b0;
   logic [31:0] trc_data = '0;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   trace_ring_buffer #(.DEPTH(D)) u_trace_ring_buffer (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_rd      (bus_rd),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .trc_valid   (trc_valid),
      .trc_data    (trc_data),
      .trc_trigger (trc_trigger)
   );

   typedef struct packed {
      logic        is_wr;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b0, A_DEPTH, 32'h0,         32'd16,        8'd1},  // R1 depth
      '{1'b1, A_POST,  32'h1234,      32'h0,         8'd1},
      '{1'b0, A_POST,  32'h0,         32'h1234,      8'd1},  // R1 readback
      '{1'b0, 12'h008, 32'h0,         32'h0,         8'd1},  // R1 unmapped
      '{1'b1, A_FCTL,  32'hFFFF_FFBF, 32'h0,         8'd12},
      '{1'b0, A_FCTL,  32'h0,         32'h0000_3001, 8'd12}, // R12 only 0/12/13 stick
      '{1'b1, A_FCTL,  32'h0,         32'h0,         8'd12},
      '{1'b0, A_FCTL,  32'h0,         32'h0,         8'd12}, // R12 cleared
      '{1'b1, A_RPTR,  32'h25,        32'h0,         8'd7},
      '{1'b0, A_RPTR,  32'h0,         32'h5,         8'd7},  // R7 37 mod 16
      '{1'b1, A_WPTR,  32'hFFFF_FFF3, 32'h0,         8'd7},
      '{1'b0, A_WPTR,  32'h0,         32'h3,         8'd7},  // R7 modulo
      '{1'b1, A_WPTR,  32'h0,         32'h0,         8'd7},
      '{1'b1, A_RPTR,  32'h0,         32'h0,         8'd7}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic stream(input int n, input int trig_at, input logic [31:0] base);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         trc_valid = 1'b1; trc_data = base + 32'(k); trc_trigger = (k == trig_at);
      end
      @(negedge clk);
      trc_valid = 1'b0; trc_trigger = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R2 reset state
      rd_chk("R2 stat",   A_STAT,  32'h0);
      rd_chk("R2 cap",    A_CAP,   32'h0);
      rd_chk("R2 fctl",   A_FCTL,  32'h0);
      rd_chk("R2 fstat",  A_FSTAT, 32'h2);
      rd_chk("R2 wptr",   A_WPTR,  32'h0);
      rd_chk("R2 rptr",   A_RPTR,  32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].is_wr) wr(VEC[i].addr, VEC[i].data);
         else begin
            rd(VEC[i].addr, v);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
         end
      end

      // R5 / R4: software fill wraps and sets full
      for (int i = 0; i < D; i++) wr(A_WDATA, 32'hA000 + 32'(i));
      rd_chk("R5 wptr after fill", A_WPTR, 32'h0);
      rd_chk("R4 full after wrap", A_STAT, 32'h1);
      wr(A_WPTR, 32'h0);
      rd_chk("R4 full cleared", A_STAT, 32'h0);

      // R6 drain with wrap
      wr(A_RPTR, 32'h0);
      for (int i = 0; i < D + 1; i++) begin
         rd(A_RDATA, v);
         chk("R6 read data", v, 32'hA000 + 32'(i % D));
      end
      rd_chk("R6 rptr wrapped", A_RPTR, 32'h1);
      rd_chk("R6 other read no advance", A_RPTR, 32'h1);

      // clear RAM to zero
      for (int i = 0; i < D; i++) wr(A_WDATA, 32'h0);
      wr(A_WPTR, 32'h0);

      // R3 capture disabled stores nothing
      stream(3, -1, 32'hBB00);
      rd_chk("R3 no store when off", A_WPTR, 32'h0);

      // R8 / R9 trigger with 6 post words
      wr(A_POST, 32'd6);
      wr(A_FCTL, 32'h2001);
      wr(A_CAP, 32'h1);
      rd_chk("R11 running", A_FSTAT, 32'h0);
      wr(A_WDATA, 32'h5555);
      rd_chk("R5 ignored while capturing", A_WPTR, 32'h0);
      stream(16, 4, 32'hD000);
      idle(2);
      rd_chk("R9 wptr aligned after trigger", A_WPTR, 32'd12);
      rd_chk("R11 stopped after trigger", A_FSTAT, 32'h2);
      rd_chk("R4 no wrap yet", A_STAT, 32'h0);
      wr(A_RPTR, 32'h0);
      for (int i = 0; i < 13; i++) begin
         rd(A_RDATA, v);
         if (i <= 10) chk("R8 stored word", v, 32'hD000 + 32'(i));
         else         chk("R9 pad or untouched slot", v, 32'h0);
      end

      // R8 trigger ignored without bit 13; R11 restart
      wr(A_FCTL, 32'h0001);
      wr(A_CAP, 32'h1);
      rd_chk("R11 restarted", A_FSTAT, 32'h0);
      stream(3, 0, 32'hF000);
      idle(2);
      rd_chk("R8 trigger ignored wptr", A_WPTR, 32'd15);
      rd_chk("R8 still running", A_FSTAT, 32'h0);

      // R10 flush with stop; padding wraps pointer
      wr(A_FCTL, 32'h1041);
      rd_chk("R10 flush pending", A_FCTL, 32'h1041);
      idle(3);
      rd_chk("R10 flush done", A_FCTL, 32'h1001);
      rd_chk("R10 halted by flush", A_FSTAT, 32'h2);
      rd_chk("R9 flush wptr", A_WPTR, 32'h0);
      rd_chk("R4 pad wrap sets full", A_STAT, 32'h1);
      wr(A_RPTR, 32'd14);
      rd_chk("R3 word kept", A_RDATA, 32'hF002);
      rd_chk("R9 flush pad", A_RDATA, 32'h0);

      // R10 flush without stop keeps running
      wr(A_CAP, 32'h1);
      stream(2, -1, 32'hC000);
      wr(A_FCTL, 32'h0041);
      idle(4);
      rd_chk("R10 flush no stop", A_FSTAT, 32'h0);
      rd_chk("R10 bit clears", A_FCTL, 32'h0001);
      rd_chk("R9 flush aligned", A_WPTR, 32'd4);
      stream(1, -1, 32'hC100);
      rd_chk("R3 resumes after flush", A_WPTR, 32'd5);

      // R11 disable
      wr(A_CAP, 32'h0);
      rd_chk("R11 stopped on disable", A_FSTAT, 32'h2);
      stream(2, -1, 32'hC200);
      rd_chk("R3 disabled drops", A_WPTR, 32'd5);

      // R8 zero post-trigger count
      wr(A_POST, 32'h0);
      wr(A_FCTL, 32'h2001);
      wr(A_CAP, 32'h1);
      stream(5, 0, 32'hE000);
      idle(2);
      rd_chk("R8 zero count wptr", A_WPTR, 32'd8);
      rd_chk("R8 zero count halted", A_FSTAT, 32'h2);
      wr(A_RPTR, 32'd5);
      rd_chk("R8 trigger word stored", A_RDATA, 32'hE000);
      rd_chk("R9 pad after zero count", A_RDATA, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule